// File: doc/BRIEF.md
# Half-Digit Static LCD Segment Driver

This block drives a static (non-multiplexed) liquid crystal display showing a signed reading of three and a half digits. A converter presents three BCD digits, a bit for the leading half digit and a sign flag, then pulses a load strobe once per conversion. The block captures these inputs into a holding register, decodes each digit to seven segments, and drives every segment line as a square wave. That wave is either in phase with a free-running backplane square wave, so the segment is dark, or in antiphase with it, so the segment is visible.

The backplane is derived from the oscillator clock by a divider, so the display never sees a DC level in normal operation. A lamp-test input overrides the drive and holds every segment line, the leading "1" line and the minus line at one static level. This lights the whole display so that it reads minus, 1, 8, 8, 8.

Top module: `lcd_halfdigit_drv`

## Requirements
- R1: `bp_o` is a square wave that holds each level for exactly `BP_HALF` clock cycles (default 400, a full period of 800 cycles). After reset is released it first goes high on the 400th rising edge.
- R2: Outside lamp test, a dark segment line equals `bp_o` and a lit segment line equals the inverse of `bp_o`. Across a backplane toggle, each line keeps its phase relation to `bp_o` unless a new value is loaded.
- R3: Each of the three digits has its own seven lines, coded with bit 0 = a, bit 1 = b, bit 2 = c, bit 3 = d, bit 4 = e, bit 5 = f and bit 6 = g. The lit-segment codes are 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F and 9=6F (hex).
- R4: A captured BCD value from 10 to 15 blanks that digit, leaving all seven of its segments dark.
- R5: `lead1_o` is lit exactly when the captured thousands bit is 1.
- R6: `minus_o` is lit exactly when the captured sign flag is 1.
- R7: Digit, thousands and sign inputs are captured only on a rising edge where `load_i` is 1. Changes to them at any other time leave every output unchanged.
- R8: While `lamp_test_i` is 1, every segment line, `lead1_o` and `minus_o` are held at the static level `LT_LEVEL` (default 1) whatever the backplane phase. `bp_o` keeps toggling. When lamp test ends, the captured reading is shown again.
- R9: An active-low reset drives `bp_o` low, clears the divider, and blanks the holding register, so that every segment line, `lead1_o` and `minus_o` are low during reset and stay dark afterwards until a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| units_bcd_i | input | 4 | Units digit, BCD |
| tens_bcd_i | input | 4 | Tens digit, BCD |
| hund_bcd_i | input | 4 | Hundreds digit, BCD |
| thou_i | input | 1 | Leading half digit (reading of 1000 or more) |
| neg_i | input | 1 | Reading is negative |
| load_i | input | 1 | Capture strobe, one cycle per conversion |
| lamp_test_i | input | 1 | Force all segments on at a static level |
| units_seg_o | output | 7 | Units segment lines a..g (bit 0 = a) |
| tens_seg_o | output | 7 | Tens segment lines a..g (bit 0 = a) |
| hund_seg_o | output | 7 | Hundreds segment lines a..g (bit 0 = a) |
| lead1_o | output | 1 | Both halves of the leading "1" |
| minus_o | output | 1 | Minus sign segment |
| bp_o | output | 1 | Backplane square wave |

## Verification
The properties assume that `load_i` and `lamp_test_i` are synchronous to `clk` and settle well before each rising edge. This matters because lamp test reaches the outputs through logic alone, and the phase-hold property only excuses output changes that follow a sampled load or a sampled lamp-test level. The stimulus changes every input at the falling edge and samples outputs there, half a cycle away from the edge at which registers move. It holds `load_i` high for exactly one cycle per capture, and it includes BCD codes above 9 because any 4-bit value is legal on the digit inputs.

// File: rtl/lcd_drv_pkg.sv
`timescale 1ns/1ps
package lcd_drv_pkg;

   localparam int unsigned NUM_DIG = 3;
   localparam int unsigned BCD_W   = 4;
   localparam int unsigned SEG_N   = 7;

   typedef logic [SEG_N-1:0] seg7_t;

   // Segment order in a seg7_t: bit 0 = a ... bit 6 = g.
   function automatic seg7_t bcd_to_seg(input logic [BCD_W-1:0] v);
      seg7_t s;
      case (v)
         4'd0:    s = 7'h3F;
         4'd1:    s = 7'h06;
         4'd2:    s = 7'h5B;
         4'd3:    s = 7'h4F;
         4'd4:    s = 7'h66;
         4'd5:    s = 7'h6D;
         4'd6:    s = 7'h7D;
         4'd7:    s = 7'h07;
         4'd8:    s = 7'h7F;
         4'd9:    s = 7'h6F;
         default: s = '0;   // codes above 9 blank the digit (R4)
      endcase
      return s;
   endfunction

endpackage

// File: rtl/lcd_bp_gen.sv
`timescale 1ns/1ps
module lcd_bp_gen #(
   parameter int unsigned HALF = 400
) (
   input  logic clk,
   input  logic rst_n,
   output logic bp_o
);
   localparam int unsigned CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

   generate
      if (HALF < 2) begin : g_bad_half
         $error("lcd_bp_gen: HALF must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             wrap;

   assign wrap = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         bp_o  <= 1'b0;
      end else begin
         cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
         if (wrap) bp_o <= ~bp_o;
      end
   end
endmodule

// File: rtl/lcd_hold_reg.sv
`timescale 1ns/1ps
module lcd_hold_reg #(
   parameter int unsigned    W       = 14,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (W < 1) begin : g_bad_w
         $error("lcd_hold_reg: W must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= RST_VAL;
      else if (load_i) q_o <= d_i;
   end
endmodule

// File: rtl/lcd_digit_font.sv
`timescale 1ns/1ps
module lcd_digit_font
   import lcd_drv_pkg::*;
(
   input  logic [BCD_W-1:0] bcd_i,
   output seg7_t            seg_o
);
   assign seg_o = bcd_to_seg(bcd_i);
endmodule

// File: rtl/lcd_seg_phaser.sv
`timescale 1ns/1ps
module lcd_seg_phaser #(
   parameter int unsigned N        = 23,
   parameter logic        LT_LEVEL = 1'b1
) (
   input  logic [N-1:0] lit_i,
   input  logic         bp_i,
   input  logic         lamp_i,
   output logic [N-1:0] drv_o
);
   generate
      if (N < 1) begin : g_bad_n
         $error("lcd_seg_phaser: N must be positive");
      end
      for (genvar k = 0; k < N; k++) begin : g_line
         assign drv_o[k] = lamp_i   ? LT_LEVEL
                         : lit_i[k] ? ~bp_i
                         :            bp_i;
      end
   endgenerate
endmodule

// File: rtl/lcd_halfdigit_drv.sv
`timescale 1ns/1ps
module lcd_halfdigit_drv
   import lcd_drv_pkg::*;
#(
   parameter int unsigned BP_HALF  = 400,
   parameter logic        LT_LEVEL = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [3:0]  units_bcd_i,
   input  logic [3:0]  tens_bcd_i,
   input  logic [3:0]  hund_bcd_i,
   input  logic        thou_i,
   input  logic        neg_i,
   input  logic        load_i,
   input  logic        lamp_test_i,
   output logic [6:0]  units_seg_o,
   output logic [6:0]  tens_seg_o,
   output logic [6:0]  hund_seg_o,
   output logic        lead1_o,
   output logic        minus_o,
   output logic        bp_o
);
   localparam int unsigned DIG_BITS = NUM_DIG * BCD_W;
   localparam int unsigned HOLD_W   = DIG_BITS + 2;
   localparam int unsigned LINE_N   = NUM_DIG * SEG_N + 2;
   localparam logic [HOLD_W-1:0] HOLD_RST = {2'b00, {NUM_DIG{4'hF}}};

   generate
      if (BCD_W != 4 || SEG_N != 7 || NUM_DIG != 3) begin : g_bad_pkg
         $error("lcd_halfdigit_drv: port widths assume 3 digits of 4-bit BCD, 7 segments");
      end
   endgenerate

   // Capture on load: {sign, thousands, hundreds, tens, units}
   logic [HOLD_W-1:0] hold_d, hold_q;
   assign hold_d = {neg_i, thou_i, hund_bcd_i, tens_bcd_i, units_bcd_i};

   lcd_hold_reg #(.W(HOLD_W), .RST_VAL(HOLD_RST)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_i),
      .d_i    (hold_d),
      .q_o    (hold_q)
   );

   // Backplane divider
   logic bp;
   lcd_bp_gen #(.HALF(BP_HALF)) u_bp (
      .clk   (clk),
      .rst_n (rst_n),
      .bp_o  (bp)
   );

   // Per-digit font decode
   logic [LINE_N-1:0] lit;
   generate
      for (genvar i = 0; i < NUM_DIG; i++) begin : g_dig
         seg7_t dseg;
         lcd_digit_font u_font (
            .bcd_i (hold_q[i*BCD_W +: BCD_W]),
            .seg_o (dseg)
         );
         assign lit[i*SEG_N +: SEG_N] = dseg;
      end
   endgenerate
   assign lit[LINE_N-2] = hold_q[DIG_BITS];      // leading "1"
   assign lit[LINE_N-1] = hold_q[DIG_BITS + 1];  // minus sign

   // AC phasing against backplane, lamp-test override
   logic [LINE_N-1:0] drv;
   lcd_seg_phaser #(.N(LINE_N), .LT_LEVEL(LT_LEVEL)) u_phase (
      .lit_i  (lit),
      .bp_i   (bp),
      .lamp_i (lamp_test_i),
      .drv_o  (drv)
   );

   assign units_seg_o = drv[0*SEG_N +: SEG_N];
   assign tens_seg_o  = drv[1*SEG_N +: SEG_N];
   assign hund_seg_o  = drv[2*SEG_N +: SEG_N];
   assign lead1_o     = drv[LINE_N-2];
   assign minus_o     = drv[LINE_N-1];
   assign bp_o        = bp;
endmodule

// File: rtl/lcd_halfdigit_drv_chk.sv
`timescale 1ns/1ps
module lcd_halfdigit_drv_chk #(
   parameter int unsigned BP_HALF  = 400,
   parameter logic        LT_LEVEL = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       load_i,
   input logic       lamp_test_i,
   input logic [6:0] units_seg_o,
   input logic [6:0] tens_seg_o,
   input logic [6:0] hund_seg_o,
   input logic       lead1_o,
   input logic       minus_o,
   input logic       bp_o
);
   localparam int unsigned RUN_W = $clog2(BP_HALF + 1) + 1;
   localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(BP_HALF);

   logic [22:0] lines;
   logic [22:0] rel;
   assign lines = {hund_seg_o, tens_seg_o, units_seg_o, lead1_o, minus_o};
   assign rel   = lines ^ {23{bp_o}};

   // Length of the current backplane level, in sampled cycles
   logic [RUN_W-1:0] run_q;
   logic             bp_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         bp_d  <= 1'b0;
      end else begin
         bp_d <= bp_o;
         if (bp_o != bp_d)    run_q <= RUN_W'(1);
         else if (run_q != '1) run_q <= run_q + RUN_W'(1);
      end
   end

   AST_BP_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= RUN_LIM);                                                     // R1

   AST_BP_LEVEL_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      (bp_o != bp_d) |-> (run_q == RUN_LIM));                                // R1

   AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!lamp_test_i && !$past(lamp_test_i) && !$past(load_i)) |-> (rel == $past(rel))); // R2

   AST_LAMP_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
      lamp_test_i |-> (lines == {23{LT_LEVEL}}));                            // R8

   AST_RESET_QUIET: assert property (@(posedge clk)
      (!rst_n && $past(!rst_n) && !lamp_test_i) |-> (!bp_o && lines == '0)); // R9
endmodule

bind lcd_halfdigit_drv lcd_halfdigit_drv_chk #(
   .BP_HALF  (BP_HALF),
   .LT_LEVEL (LT_LEVEL)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .load_i      (load_i),
   .lamp_test_i (lamp_test_i),
   .units_seg_o (units_seg_o),
   .tens_seg_o  (tens_seg_o),
   .hund_seg_o  (hund_seg_o),
   .lead1_o     (lead1_o),
   .minus_o     (minus_o),
   .bp_o        (bp_o)
);

// File: tb/lcd_halfdigit_drv_bench.sv
`timescale 1ns/1ps
module lcd_halfdigit_drv_bench;
   localparam int HALF = 400;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n = 1'b0;
   logic [3:0] u_bcd = '0, t_bcd = '0, h_bcd = '0;
   logic       thou = 1'b0, neg = 1'b0, load = 1'b0, lamp = 1'b0;
   logic [6:0] u_seg, t_seg, h_seg;
   logic       lead1, minus, bp;

   lcd_halfdigit_drv u_lcd_halfdigit_drv (
      .clk(clk), .rst_n(rst_n),
      .units_bcd_i(u_bcd), .tens_bcd_i(t_bcd), .hund_bcd_i(h_bcd),
      .thou_i(thou), .neg_i(neg), .load_i(load), .lamp_test_i(lamp),
      .units_seg_o(u_seg), .tens_seg_o(t_seg), .hund_seg_o(h_seg),
      .lead1_o(lead1), .minus_o(minus), .bp_o(bp)
   );

   int n_chk = 0, n_fail = 0, edges = 0;
   bit done = 0;

   always @(posedge clk or negedge rst_n)
      if (!rst_n) edges <= 0; else edges <= edges + 1;

   // {u, t, h, thou, neg, exp_u, exp_t, exp_h}: lit-segment masks, bit0=a
   localparam logic [34:0] VEC [8] = '{
      {4'd0, 4'd1, 4'd2, 1'b0, 1'b0, 7'h3F, 7'h06, 7'h5B},
      {4'd3, 4'd4, 4'd5, 1'b1, 1'b1, 7'h4F, 7'h66, 7'h6D},
      {4'd6, 4'd7, 4'd8, 1'b1, 1'b0, 7'h7D, 7'h07, 7'h7F},
      {4'd9, 4'd0, 4'd1, 1'b0, 1'b1, 7'h6F, 7'h3F, 7'h06},
      {4'hA, 4'd9, 4'hF, 1'b0, 1'b0, 7'h00, 7'h6F, 7'h00},
      {4'd8, 4'hC, 4'd6, 1'b1, 1'b1, 7'h7F, 7'h00, 7'h7D},
      {4'd2, 4'd5, 4'hB, 1'b1, 1'b0, 7'h5B, 7'h6D, 7'h00},
      {4'd7, 4'd3, 4'd4, 1'b0, 1'b1, 7'h07, 7'h4F, 7'h66}
   };

   function automatic logic exp_bp();
      return ((edges / HALF) % 2) == 1;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_disp(input string req, input logic [6:0] eu, et, eh,
                             input logic eth, en);
      logic b;
      b = exp_bp();
      chk("R1", "bp", 32'(bp), 32'(b));
      chk(req, "units", 32'(u_seg), 32'(eu ^ {7{b}}));
      chk(req, "tens",  32'(t_seg), 32'(et ^ {7{b}}));
      chk(req, "hund",  32'(h_seg), 32'(eh ^ {7{b}}));
      chk(req, "lead1", 32'(lead1), 32'(eth ^ b));
      chk(req, "minus", 32'(minus), 32'(en ^ b));
   endtask

   task automatic do_load(input logic [3:0] u, t, h, input logic th, n);
      @(negedge clk);
      u_bcd = u; t_bcd = t; h_bcd = h; thou = th; neg = n; load = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      // R9: reset state
      repeat (3) @(negedge clk);
      chk("R9", "bp in reset", 32'(bp), 32'd0);
      chk("R9", "lines in reset", 32'({h_seg, t_seg, u_seg, lead1, minus}), 32'd0);
      rst_n = 1'b1;

      // R1: first rise on edge 400; R9: blank display follows bp
      while (edges < HALF - 1) @(negedge clk);
      chk("R1", "bp before first toggle", 32'(bp), 32'd0);
      check_disp("R9", 7'h00, 7'h00, 7'h00, 1'b0, 1'b0);
      @(negedge clk);
      chk("R1", "bp first toggle", 32'(bp), 32'd1);
      check_disp("R9", 7'h00, 7'h00, 7'h00, 1'b0, 1'b0);

      // R2 R3 R4 R5 R6: table walk, both backplane phases
      for (int i = 0; i < 8; i++) begin
         logic [34:0] v;
         v = VEC[i];
         do_load(v[34:31], v[30:27], v[26:23], v[22], v[21]);
         check_disp("R2 R3 R4 R5 R6", v[20:14], v[13:7], v[6:0], v[22], v[21]);
         repeat (HALF) @(negedge clk);
         check_disp("R2 R3 R4 R5 R6", v[20:14], v[13:7], v[6:0], v[22], v[21]);
      end

      // R7: inputs change with no load, display keeps last capture
      @(negedge clk);
      u_bcd = 4'd1; t_bcd = 4'd1; h_bcd = 4'd1; thou = 1'b1; neg = 1'b0;
      repeat (50) @(negedge clk);
      check_disp("R7", 7'h07, 7'h4F, 7'h66, 1'b0, 1'b1);

      // R8: lamp test holds static level across a backplane toggle
      lamp = 1'b1;
      #1;
      chk("R8", "lines lamp", 32'({h_seg, t_seg, u_seg, lead1, minus}), 32'h7FFFFF);
      repeat (HALF) @(negedge clk);
      chk("R8", "lines lamp after toggle", 32'({h_seg, t_seg, u_seg, lead1, minus}), 32'h7FFFFF);
      chk("R8", "bp runs in lamp", 32'(bp), 32'(exp_bp()));
      lamp = 1'b0;
      #1;
      check_disp("R8", 7'h07, 7'h4F, 7'h66, 1'b0, 1'b1);

      // R9: reset mid-run clears divider and blanks the reading
      repeat (123) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R9", "bp async reset", 32'(bp), 32'd0);
      chk("R9", "lines async reset", 32'({h_seg, t_seg, u_seg, lead1, minus}), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      while (edges < HALF - 1) @(negedge clk);
      chk("R9", "divider restarted", 32'(bp), 32'd0);
      @(negedge clk);
      chk("R9", "divider restarted toggle", 32'(bp), 32'd1);
      check_disp("R9", 7'h00, 7'h00, 7'h00, 1'b0, 1'b0);

      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule